// File: doc/BRIEF.md
# Flash Cache Control and Statistics Registers

This block is the register slice that governs a flash execute-in-place cache. A word-wide register bus reaches five word registers: a control word holding the cache enable, the bad-write fault policy and the power-down bit; a self-clearing flush trigger; a status word; and two saturating statistics counters. The rest of the cache (tag and data memories, flash interface, bus fabric) sits outside the block and talks to it through plain ports.

A flush walks every tag line once, clearing its valid bit through a tag-clear strobe and line index, one line per clock. A flush runs by itself out of reset and again whenever software writes a 1 to the flush register. A read of the flush register holds the bus with wait states until the walk is done, which gives software a blocking wait. The block also decides, from the control bits, whether a cache-as-SRAM access or a write to a non-default address alias gets an error response. It counts the single-cycle hit and access strobes raised by the cache datapath.

Top module: `flashcache_ctrl`

## Requirements
- R1: After reset the control word reads 3 (bit 0 enable = 1, bit 1 bad-write fault = 1, bit 2 power-down = 0), and both counters read 0. Word addresses: 0 control, 1 flush, 2 status, 3 hit counter, 4 access counter.
- R2: When a control write sets power-down (bit 2), enable reads 0 whatever bit 0 of that write holds. `cache_enabled` is never 1 while `cache_pwr_down` is 1.
- R3: `sram_err` is 1 for a `sram_req` whenever the cache is enabled or powered down, and 0 when the cache is neither.
- R4: For an `alias_wr`, `alias_wr_err` is 1 when the bad-write fault bit is 1; otherwise `alias_wr_drop` is 1. Exactly one of the two is raised.
- R5: Writing 1 to bit 0 of the flush register starts a walk that raises `tag_clr_valid` for LINES consecutive cycles, with `tag_clr_idx` running 0, 1, ..., LINES-1, starting in the cycle after the write. A new flush write restarts the walk at line 0.
- R6: Status bit 0 (flush done) reads 0 while a walk runs and 1 otherwise. A walk starts right after reset, so the bit reads 0 just after reset.
- R7: A read of the flush register holds `reg_ready` low until the walk ends and then returns 0. Writes never stall.
- R8: The access counter adds one for each cycle with `stat_access` high, and the hit counter adds one for each cycle with `stat_hit` high. The two strobes act on their own counters only.
- R9: Each counter (CNT_W bits, 32 by default) stops at all ones.
- R10: A write of any value to a counter clears it to 0. The clear wins over an increment strobe in the same cycle.
- R11: Writing a value with bit 0 clear to the flush register starts no walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request, held until reg_ready |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_ready is high |
| reg_ready | output | 1 | Access completes on the clock edge where this is high |
| stat_hit | input | 1 | Single-cycle strobe: access served from cached data |
| stat_access | input | 1 | Single-cycle strobe: any execute-in-place access |
| sram_req | input | 1 | Cache-as-SRAM access in this cycle |
| sram_err | output | 1 | Error response for the SRAM access |
| alias_wr | input | 1 | Write to a non-caching or non-allocating alias |
| alias_wr_err | output | 1 | Fault response for that write |
| alias_wr_drop | output | 1 | That write is silently dropped |
| cache_enabled | output | 1 | Cache lookups allowed |
| cache_pwr_down | output | 1 | Cache memories powered down |
| tag_clr_valid | output | 1 | Clear the valid bit of line tag_clr_idx |
| tag_clr_idx | output | $clog2(LINES) | Tag line being cleared |

## Verification
Two pairs of functions can act in the same cycle. A write that clears a counter can land in the same cycle as its increment strobe. The bench holds the strobe high across the write edge and expects the counter to read 0 afterwards, while the other counter has moved on unaffected. A blocking read of the flush register also overlaps the tag walk. The bench issues the read right after the flush write, counts its wait cycles against LINES, and samples the line index cycle by cycle during a separate walk.

// File: rtl/flashcache_pkg.sv
package flashcache_pkg;

    localparam int REG_ADDR_W = 3;
    localparam int REG_DATA_W = 32;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_CTRL     = 3'd0,
        SEL_FLUSH    = 3'd1,
        SEL_STATUS   = 3'd2,
        SEL_HITS     = 3'd3,
        SEL_ACCESSES = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic pwr_down;
        logic wr_fault;
        logic enable;
    } ctrl_bits_t;

    localparam ctrl_bits_t CTRL_RESET = '{pwr_down: 1'b0, wr_fault: 1'b1, enable: 1'b1};

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } reg_cmd_t;

    // Power-down dominates: enable can only land when power-down is clear.
    function automatic ctrl_bits_t ctrl_apply(input ctrl_bits_t w);
        ctrl_bits_t r;
        r.pwr_down = w.pwr_down;
        r.wr_fault = w.wr_fault;
        r.enable   = w.enable & ~w.pwr_down;
        return r;
    endfunction

endpackage

// File: rtl/fc_ctrl_bits.sv
module fc_ctrl_bits
    import flashcache_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  ctrl_bits_t wr_val,
    output ctrl_bits_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CTRL_RESET;
        end else if (wr_en) begin
            q <= ctrl_apply(wr_val);
        end
    end
endmodule

// File: rtl/fc_flush_seq.sv
module fc_flush_seq #(
    parameter int LINES = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    output logic                      busy,
    output logic [$clog2(LINES)-1:0]  line
);
    localparam int LINE_W = $clog2(LINES);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b1;
            line <= '0;
        end else if (start) begin
            busy <= 1'b1;
            line <= '0;
        end else if (busy) begin
            if (line == LAST_LINE) begin
                busy <= 1'b0;
            end else begin
                line <= line + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fc_sat_counter.sv
module fc_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/flashcache_ctrl.sv
module flashcache_ctrl
    import flashcache_pkg::*;
#(
    parameter int LINES = 64,
    parameter int CNT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_req,
    input  logic                     reg_we,
    input  logic [2:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic                     reg_ready,
    input  logic                     stat_hit,
    input  logic                     stat_access,
    input  logic                     sram_req,
    output logic                     sram_err,
    input  logic                     alias_wr,
    output logic                     alias_wr_err,
    output logic                     alias_wr_drop,
    output logic                     cache_enabled,
    output logic                     cache_pwr_down,
    output logic                     tag_clr_valid,
    output logic [$clog2(LINES)-1:0] tag_clr_idx
);
    localparam int LINE_W = $clog2(LINES);
    localparam int N_CNT  = 2;

    reg_cmd_t   cmd;
    ctrl_bits_t ctrl_q;
    logic       flush_busy;
    logic       flush_start;
    logic       stall;

    logic [N_CNT-1:0] cnt_inc;
    logic [N_CNT-1:0] cnt_clr;
    logic [CNT_W-1:0] cnt_val [N_CNT];
    logic [CNT_W-1:0] hit_q;
    logic [CNT_W-1:0] acc_q;
    logic [LINE_W-1:0] walk_line;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[31:3];

    // Access decode: a read of the flush word waits out a running walk.
    assign stall     = reg_req && !reg_we && (reg_sel_e'(reg_addr) == SEL_FLUSH) && flush_busy;
    assign reg_ready = !stall;
    assign cmd.sel   = reg_sel_e'(reg_addr);
    assign cmd.wr    = reg_req && reg_we;
    assign cmd.rd    = reg_req && !reg_we && reg_ready;

    fc_ctrl_bits u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cmd.wr && cmd.sel == SEL_CTRL),
        .wr_val (ctrl_bits_t'(reg_wdata[2:0])),
        .q      (ctrl_q)
    );

    assign flush_start = cmd.wr && (cmd.sel == SEL_FLUSH) && reg_wdata[0];

    fc_flush_seq #(.LINES(LINES)) u_flush (
        .clk   (clk),
        .rst   (rst),
        .start (flush_start),
        .busy  (flush_busy),
        .line  (walk_line)
    );

    assign tag_clr_valid = flush_busy;
    assign tag_clr_idx   = walk_line;

    // Statistics counters: index 0 hits, index 1 accesses.
    assign cnt_inc[0] = stat_hit;
    assign cnt_inc[1] = stat_access;
    assign cnt_clr[0] = cmd.wr && (cmd.sel == SEL_HITS);
    assign cnt_clr[1] = cmd.wr && (cmd.sel == SEL_ACCESSES);

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        fc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (cnt_inc[g]),
            .clr   (cnt_clr[g]),
            .count (cnt_val[g])
        );
    end

    assign hit_q = cnt_val[0];
    assign acc_q = cnt_val[1];

    // Response policy toward the cache datapath.
    assign cache_enabled  = ctrl_q.enable && !ctrl_q.pwr_down;
    assign cache_pwr_down = ctrl_q.pwr_down;
    assign sram_err       = sram_req && (ctrl_q.enable || ctrl_q.pwr_down);
    assign alias_wr_err   = alias_wr && ctrl_q.wr_fault;
    assign alias_wr_drop  = alias_wr && !ctrl_q.wr_fault;

    always_comb begin
        reg_rdata = '0;
        if (cmd.rd) begin
            unique case (cmd.sel)
                SEL_CTRL:     reg_rdata[2:0] = ctrl_q;
                SEL_FLUSH:    reg_rdata = '0;
                SEL_STATUS:   reg_rdata[0] = !flush_busy;
                SEL_HITS:     reg_rdata[CNT_W-1:0] = hit_q;
                SEL_ACCESSES: reg_rdata[CNT_W-1:0] = acc_q;
                default:      reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/flashcache_ctrl_chk.sv
module flashcache_ctrl_chk #(
    parameter int LINES = 64,
    parameter int CNT_W = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     reg_req,
    input logic                     reg_we,
    input logic [2:0]               reg_addr,
    input logic [31:0]              reg_wdata,
    input logic                     reg_ready,
    input logic                     sram_req,
    input logic                     sram_err,
    input logic                     alias_wr,
    input logic                     alias_wr_err,
    input logic                     alias_wr_drop,
    input logic                     cache_enabled,
    input logic                     cache_pwr_down,
    input logic                     tag_clr_valid,
    input logic [$clog2(LINES)-1:0] tag_clr_idx,
    input logic [CNT_W-1:0]         hit_count
);
    localparam int LINE_W = $clog2(LINES);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic flush_cmd;
    logic hit_wr;
    assign flush_cmd = reg_req && reg_we && reg_addr == 3'd1 && reg_wdata[0];
    assign hit_wr    = reg_req && reg_we && reg_addr == 3'd3;

    AST_PD_OVERRIDES_EN: assert property (@(posedge clk) disable iff (rst)
        cache_pwr_down |-> !cache_enabled); // R2

    AST_SRAM_ERR_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        sram_req && (cache_enabled || cache_pwr_down) |-> sram_err); // R3

    AST_ALIAS_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        alias_wr |-> $countones({alias_wr_err, alias_wr_drop}) == 1); // R4

    AST_FLUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        tag_clr_valid && $past(tag_clr_valid) && !$past(rst) && !$past(flush_cmd)
        |-> tag_clr_idx == LINE_W'($past(tag_clr_idx) + 1'b1)); // R5

    AST_STALL_ONLY_IN_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !reg_ready |-> tag_clr_valid); // R7

    AST_WRITES_NEVER_STALL: assert property (@(posedge clk) disable iff (rst)
        reg_req && reg_we |-> reg_ready); // R7

    AST_HIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        hit_wr |=> hit_count == '0); // R10

    AST_HIT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        hit_count == FULL && !hit_wr |=> hit_count == FULL); // R9

    AST_HIT_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        !hit_wr |=> hit_count >= $past(hit_count)); // R8
endmodule

bind flashcache_ctrl flashcache_ctrl_chk #(.LINES(LINES), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_req        (reg_req),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_ready      (reg_ready),
    .sram_req       (sram_req),
    .sram_err       (sram_err),
    .alias_wr       (alias_wr),
    .alias_wr_err   (alias_wr_err),
    .alias_wr_drop  (alias_wr_drop),
    .cache_enabled  (cache_enabled),
    .cache_pwr_down (cache_pwr_down),
    .tag_clr_valid  (tag_clr_valid),
    .tag_clr_idx    (tag_clr_idx),
    .hit_count      (hit_q)
);

// File: tb/flashcache_ctrl_bench.sv
`timescale 1ns/1ps
module flashcache_ctrl_bench;
    localparam int LINES  = 8;
    localparam int CNT_W  = 4;
    localparam int LINE_W = $clog2(LINES);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_req = 1'b0;
    logic              reg_we = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              reg_ready;
    logic              stat_hit = 1'b0;
    logic              stat_access = 1'b0;
    logic              sram_req = 1'b0;
    logic              sram_err;
    logic              alias_wr = 1'b0;
    logic              alias_wr_err;
    logic              alias_wr_drop;
    logic              cache_enabled;
    logic              cache_pwr_down;
    logic              tag_clr_valid;
    logic [LINE_W-1:0] tag_clr_idx;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flashcache_ctrl #(.LINES(LINES), .CNT_W(CNT_W)) u_flashcache_ctrl (
        .clk(clk), .rst(rst),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
        .stat_hit(stat_hit), .stat_access(stat_access),
        .sram_req(sram_req), .sram_err(sram_err),
        .alias_wr(alias_wr), .alias_wr_err(alias_wr_err), .alias_wr_drop(alias_wr_drop),
        .cache_enabled(cache_enabled), .cache_pwr_down(cache_pwr_down),
        .tag_clr_valid(tag_clr_valid), .tag_clr_idx(tag_clr_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d, output int waits);
        waits = 0;
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1;
        while (!reg_ready) begin
            @(negedge clk); #1;
            waits++;
        end
        d = reg_rdata;
        @(negedge clk);
        reg_req = 1'b0;
    endtask

    task automatic expect_walk(input string req);
        for (int k = 0; k < LINES; k++) begin
            check({req, " clr_valid"}, 32'(tag_clr_valid), 32'd1);
            check({req, " clr_idx"}, 32'(tag_clr_idx), k);
            @(negedge clk);
        end
        check({req, " walk ended"}, 32'(tag_clr_valid), 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d; int w;
        reg_read(3'd2, d, w);
        check("R6 status right after reset", d, 32'd0);
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        expect_walk("R6 reset walk");
        reg_read(3'd2, d, w);
        check("R6 status after walk", d, 32'd1);
        reg_read(3'd0, d, w);
        check("R1 ctrl reset", d, 32'd3);
        reg_read(3'd3, d, w);
        check("R1 hit reset", d, 32'd0);
        reg_read(3'd4, d, w);
        check("R1 access reset", d, 32'd0);
    endtask

    task automatic t_ctrl;
        logic [31:0] d; int w;
        reg_write(3'd0, 32'h5);
        reg_read(3'd0, d, w);
        check("R2 pd with en write", d, 32'h4);
        check("R2 cache_enabled low", 32'(cache_enabled), 32'd0);
        reg_write(3'd0, 32'h1);
        reg_read(3'd0, d, w);
        check("R2 enable after pd cleared", d, 32'h1);
        check("R2 cache_enabled high", 32'(cache_enabled), 32'd1);
        reg_write(3'd0, 32'h4);
        reg_read(3'd0, d, w);
        check("R2 pd forces en 0", d, 32'h4);
        reg_write(3'd0, 32'h7);
        reg_read(3'd0, d, w);
        check("R2 en blocked while pd", d, 32'h6);
    endtask

    task automatic t_sram;
        reg_write(3'd0, 32'h0);
        sram_req = 1'b1; #1;
        check("R3 idle cache no err", 32'(sram_err), 32'd0);
        @(negedge clk);
        reg_write(3'd0, 32'h1); #1;
        check("R3 enabled err", 32'(sram_err), 32'd1);
        @(negedge clk);
        reg_write(3'd0, 32'h4); #1;
        check("R3 powered down err", 32'(sram_err), 32'd1);
        sram_req = 1'b0; #1;
        check("R3 no req no err", 32'(sram_err), 32'd0);
        @(negedge clk);
    endtask

    task automatic t_alias;
        reg_write(3'd0, 32'h2);
        alias_wr = 1'b1; #1;
        check("R4 fault on", {30'd0, alias_wr_err, alias_wr_drop}, 32'h2);
        @(negedge clk);
        reg_write(3'd0, 32'h0); #1;
        check("R4 fault off drops", {30'd0, alias_wr_err, alias_wr_drop}, 32'h1);
        alias_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_flush;
        logic [31:0] d; int w;
        reg_write(3'd1, 32'h1);
        expect_walk("R5 flush walk");
        reg_write(3'd1, 32'h1);
        repeat (3) @(negedge clk);
        reg_write(3'd1, 32'h1);
        expect_walk("R5 restart walk");
        reg_write(3'd1, 32'h2);
        check("R11 no walk on bit0 clear", 32'(tag_clr_valid), 32'd0);
        reg_read(3'd2, d, w);
        check("R11 status stays done", d, 32'd1);
    endtask

    task automatic t_stall;
        logic [31:0] d; int w;
        reg_write(3'd1, 32'h1);
        reg_read(3'd1, d, w);
        check("R7 wait cycles", w, LINES);
        check("R7 flush reads 0", d, 32'd0);
        reg_read(3'd2, d, w);
        check("R7 done after stall", d, 32'd1);
        check("R7 status read no wait", w, 32'd0);
    endtask

    task automatic t_counters;
        logic [31:0] d; int w;
        reg_write(3'd3, 32'h0);
        reg_write(3'd4, 32'h0);
        for (int i = 0; i < 5; i++) begin
            stat_access = 1'b1; stat_hit = (i % 2 == 0);
            @(negedge clk);
        end
        stat_access = 1'b0; stat_hit = 1'b0;
        reg_read(3'd3, d, w);
        check("R8 hit count", d, 32'd3);
        reg_read(3'd4, d, w);
        check("R8 access count", d, 32'd5);
        stat_access = 1'b1;
        repeat (20) @(negedge clk);
        stat_access = 1'b0;
        reg_read(3'd4, d, w);
        check("R9 access saturates", d, 32'hF);
        reg_read(3'd3, d, w);
        check("R8 hit untouched by access", d, 32'd3);
        stat_hit = 1'b1; stat_access = 1'b1;
        reg_write(3'd3, 32'hDEAD);
        stat_hit = 1'b0; stat_access = 1'b0;
        reg_read(3'd3, d, w);
        check("R10 clear wins over strobe", d, 32'd0);
        reg_read(3'd4, d, w);
        check("R9 access still full", d, 32'hF);
        reg_write(3'd4, 32'h0);
        reg_read(3'd4, d, w);
        check("R10 access cleared", d, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_sram();
        t_alias();
        t_flush();
        t_stall();
        t_counters();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule